// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Controller

This block computes the frequency-offset word for the feedback divider of a fractional-N clock synthesizer, so that the synthesized clock sweeps below its nominal frequency in a triangular shape. It runs from the 27 MHz reference clock. Every reference cycle it presents a signed offset, in parts per million (ppm) of nominal frequency, that is never positive.

Two select inputs each carry one of three levels (low, middle, high), already digitized upstream into a 2-bit code. Together they choose one of nine depth settings. Two of those settings are test settings with no spread. A new selection is applied only when the triangle returns to zero offset, so the output never jumps. A `settled` flag reports when a full sweep period has completed at the currently selected depth.

Top module: `spread_profile_gen`

## Requirements
- R1: `offsetPpm` is never greater than zero. The clock moves only below nominal.
- R2: Level code on each select input: 2'b00 low, 2'b01 middle, 2'b10 high, 2'b11 also high. The depth (first input `selHi`, second input `selLo`) is: low,middle 5000 ppm; low,high 3750 ppm; middle,low 2500 ppm; middle,middle 7500 ppm; middle,high 10000 ppm; high,low 15000 ppm.
- R3: The low,low setting and the two test settings high,middle and high,high give an offset of exactly zero at all times.
- R4: After reset the offset falls for HALF_CYCLES (422) cycles and reaches exactly minus the depth on the 422nd clock. It then rises for 422 cycles and reaches exactly zero on the 844th clock. The period is therefore 844 cycles, about 31.99 kHz at 27 MHz.
- R5: Both ramps are linear. Sampled k cycles into a ramp, the magnitude is within 2 ppm of k*depth/422 on the falling ramp and within 2 ppm of depth - k*depth/422 on the rising ramp.
- R6: The offset changes by at most 46 ppm between consecutive cycles. This is below 0.125 % per microsecond at 27 MHz.
- R7: A new select code is registered one cycle after it is applied. It changes the depth only on the clock at which the rising ramp returns to zero. Until then, the peak of the current period keeps the old depth.
- R8: `settled` is 0 after reset. It drops to 0 one cycle after the registered selection differs from the depth in use. It is set on a return to zero only when the period that just ended ran at the registered selection. After reset, this first happens on clock 844.
- R9: A synchronous active-high reset gives zero offset, starts the falling ramp, and takes its depth from the select inputs present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| selHi | input | 2 | First three-level select, digitized |
| selLo | input | 2 | Second three-level select, digitized |
| offsetPpm | output | OFFSET_W (16) | Signed frequency offset in ppm, never positive |
| settled | output | 1 | A full period has completed at the selected depth |

## Verification
Two events can coincide on one clock: the registered selection changing, and the rising ramp returning to zero. At that clock the return to zero both loads the depth and evaluates `settled`. The bench changes the select inputs so that the registered copy updates either one clock before that return or exactly on it. In the first case the new depth must appear at the next peak and `settled` must stay low. In the second case the old period must be reported as settled, and the flag must drop one clock later. The next peak must still show the old depth, and the new depth must appear one period after that.

// File: rtl/spread_pkg.sv
package spread_pkg;

  // Spread depth settings; the numeric order indexes the step tables.
  typedef enum logic [2:0] {
    SPREAD_OFF  = 3'd0,
    SPREAD_025  = 3'd1,
    SPREAD_0375 = 3'd2,
    SPREAD_050  = 3'd3,
    SPREAD_075  = 3'd4,
    SPREAD_100  = 3'd5,
    SPREAD_150  = 3'd6
  } depth_e;

  // Strobes from the ramp sequencer to the accumulator; exactly one is active per cycle.
  typedef struct packed {
    logic deepen;   // falling ramp: magnitude grows by one step
    logic hitPeak;  // last falling cycle: magnitude forced to depth
    logic shallow;  // rising ramp: magnitude shrinks by one step
    logic hitZero;  // last rising cycle: magnitude forced to zero
  } ramp_ctrl_t;

  function automatic int depthPpm(input int idx);
    case (idx)
      int'(SPREAD_025):  return 2500;
      int'(SPREAD_0375): return 3750;
      int'(SPREAD_050):  return 5000;
      int'(SPREAD_075):  return 7500;
      int'(SPREAD_100):  return 10000;
      int'(SPREAD_150):  return 15000;
      default:           return 0;
    endcase
  endfunction

  // Level code: 00 low, 01 middle, 10 high, 11 treated as high.
  function automatic depth_e decodeSelect(input logic [1:0] hi, input logic [1:0] lo);
    logic [1:0] hiN;
    logic [1:0] loN;
    hiN = (hi == 2'b11) ? 2'b10 : hi;
    loN = (lo == 2'b11) ? 2'b10 : lo;
    case ({hiN, loN})
      4'b0001: return SPREAD_050;
      4'b0010: return SPREAD_0375;
      4'b0100: return SPREAD_025;
      4'b0101: return SPREAD_075;
      4'b0110: return SPREAD_100;
      4'b1000: return SPREAD_150;
      default: return SPREAD_OFF;
    endcase
  endfunction

endpackage

// File: rtl/spread_select_sync.sv
module spread_select_sync
  import spread_pkg::*;
(
  input  logic       clk,
  input  logic [1:0] selHi,
  input  logic [1:0] selLo,
  output depth_e     rawDepth,
  output depth_e     sampledDepth
);

  always_comb rawDepth = decodeSelect(selHi, selLo);

  always_ff @(posedge clk) begin
    sampledDepth <= rawDepth;
  end

endmodule

// File: rtl/spread_ramp_fsm.sv
module spread_ramp_fsm
  import spread_pkg::*;
#(
  parameter int HALF_CYCLES = 422
) (
  input  logic       clk,
  input  logic       rst,
  input  depth_e     rawDepth,
  input  depth_e     sampledDepth,
  output ramp_ctrl_t ctrl,
  output depth_e     activeDepth,
  output logic       settled
);

  localparam int CNT_W = $clog2(HALF_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             rising;
  logic             lastCycle;

  always_comb begin
    lastCycle    = (phaseCnt == LAST);
    ctrl.deepen  = !rising && !lastCycle;
    ctrl.hitPeak = !rising &&  lastCycle;
    ctrl.shallow =  rising && !lastCycle;
    ctrl.hitZero =  rising &&  lastCycle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt    <= '0;
      rising      <= 1'b0;
      activeDepth <= rawDepth;
      settled     <= 1'b0;
    end else begin
      if (lastCycle) begin
        phaseCnt <= '0;
        rising   <= !rising;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end

      if (ctrl.hitZero) begin
        activeDepth <= sampledDepth;
        settled     <= (sampledDepth == activeDepth);
      end else if (sampledDepth != activeDepth) begin
        settled <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spread_accum.sv
module spread_accum
  import spread_pkg::*;
#(
  parameter int HALF_CYCLES = 422,
  parameter int FRAC_BITS   = 16,
  parameter int OFFSET_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ramp_ctrl_t                 ctrl,
  input  depth_e                     activeDepth,
  output logic signed [OFFSET_W-1:0] offsetPpm
);

  localparam int MAG_W = OFFSET_W - 1;
  localparam int ACC_W = MAG_W + FRAC_BITS;
  localparam int SLOTS = 1 << $bits(depth_e);

  logic [ACC_W-1:0] stepArr [SLOTS];
  logic [ACC_W-1:0] peakArr [SLOTS];
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] peak;
  logic [MAG_W-1:0] mag;

  // Per-depth step and peak in fixed point, folded to constants at elaboration.
  for (genvar i = 0; i < SLOTS; i++) begin : g_table
    localparam longint PeakFix = longint'(depthPpm(i)) <<< FRAC_BITS;
    localparam longint StepFix = PeakFix / HALF_CYCLES;
    assign peakArr[i] = PeakFix[ACC_W-1:0];
    assign stepArr[i] = StepFix[ACC_W-1:0];
  end

  always_comb begin
    step = stepArr[activeDepth];
    peak = peakArr[activeDepth];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (ctrl.deepen) begin
      acc <= acc + step;
    end else if (ctrl.hitPeak) begin
      acc <= peak;
    end else if (ctrl.shallow) begin
      acc <= (acc > step) ? acc - step : '0;
    end else if (ctrl.hitZero) begin
      acc <= '0;
    end
  end

  always_comb begin
    mag       = acc[ACC_W-1:FRAC_BITS];
    offsetPpm = -$signed({1'b0, mag});
  end

endmodule

// File: rtl/spread_profile_gen.sv
module spread_profile_gen
  import spread_pkg::*;
#(
  parameter int HALF_CYCLES = 422,
  parameter int FRAC_BITS   = 16,
  parameter int OFFSET_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 selHi,
  input  logic [1:0]                 selLo,
  output logic signed [OFFSET_W-1:0] offsetPpm,
  output logic                       settled
);

  depth_e     rawDepth;
  depth_e     sampledDepth;
  depth_e     activeDepth;
  ramp_ctrl_t ctrl;

  spread_select_sync i_select (
    .clk          (clk),
    .selHi        (selHi),
    .selLo        (selLo),
    .rawDepth     (rawDepth),
    .sampledDepth (sampledDepth)
  );

  spread_ramp_fsm #(
    .HALF_CYCLES (HALF_CYCLES)
  ) i_fsm (
    .clk          (clk),
    .rst          (rst),
    .rawDepth     (rawDepth),
    .sampledDepth (sampledDepth),
    .ctrl         (ctrl),
    .activeDepth  (activeDepth),
    .settled      (settled)
  );

  spread_accum #(
    .HALF_CYCLES (HALF_CYCLES),
    .FRAC_BITS   (FRAC_BITS),
    .OFFSET_W    (OFFSET_W)
  ) i_accum (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .activeDepth (activeDepth),
    .offsetPpm   (offsetPpm)
  );

endmodule

// File: rtl/spread_checker.sv
module spread_checker
  import spread_pkg::*;
#(
  parameter int HALF_CYCLES  = 422,
  parameter int OFFSET_W     = 16,
  parameter int MAX_STEP_PPM = 46
) (
  input logic                       clk,
  input logic                       rst,
  input logic signed [OFFSET_W-1:0] offsetPpm,
  input logic                       settled,
  input depth_e                     activeDepth,
  input ramp_ctrl_t                 ctrl
);

  int periodCnt;

  always_ff @(posedge clk) begin
    if (rst || ctrl.hitZero) periodCnt <= 0;
    else                     periodCnt <= periodCnt + 1;
  end

  assert_down_only_R1: assert property (@(posedge clk) disable iff (rst)
    offsetPpm <= 0);

  assert_zero_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    activeDepth == SPREAD_OFF |-> offsetPpm == '0);

  assert_depth_bound_R4: assert property (@(posedge clk) disable iff (rst)
    -int'(offsetPpm) <= depthPpm(int'(activeDepth)));

  assert_period_len_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.hitZero |-> periodCnt == 2 * HALF_CYCLES - 1);

  assert_slew_bound_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((int'(offsetPpm) - int'($past(offsetPpm)) <= MAX_STEP_PPM) &&
              (int'($past(offsetPpm)) - int'(offsetPpm) <= MAX_STEP_PPM)));

  assert_settle_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($rose(settled) |-> $past(ctrl.hitZero)));

endmodule

bind spread_profile_gen spread_checker #(
  .HALF_CYCLES (HALF_CYCLES),
  .OFFSET_W    (OFFSET_W)
) i_checker (
  .clk         (clk),
  .rst         (rst),
  .offsetPpm   (offsetPpm),
  .settled     (settled),
  .activeDepth (activeDepth),
  .ctrl        (ctrl)
);

// File: tb/test_spread_profile_gen.sv
module test_spread_profile_gen;

  localparam int HALF = 422;
  localparam int NV   = 12;

  localparam logic [1:0] V_HI [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1,
                                       2'd1, 2'd2, 2'd2, 2'd2, 2'd3, 2'd3};
  localparam logic [1:0] V_LO [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1,
                                       2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd2};
  localparam int V_DEPTH [NV] = '{0, 5000, 3750, 3750, 2500, 7500,
                                  10000, 15000, 0, 0, 15000, 0};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        selHi = 2'd0;
  logic [1:0]        selLo = 2'd0;
  logic signed [15:0] offsetPpm;
  logic              settled;

  int checks = 0;
  int errors = 0;
  int maxDelta = 0;
  int prevOff = 0;
  bit prevValid = 1'b0;

  always #5 clk = ~clk;

  spread_profile_gen i_spread_profile_gen (
    .clk       (clk),
    .rst       (rst),
    .selHi     (selHi),
    .selLo     (selLo),
    .offsetPpm (offsetPpm),
    .settled   (settled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startAt(input logic [1:0] hi, input logic [1:0] lo);
    @(negedge clk);
    selHi = hi;
    selLo = lo;
    rst   = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Slew monitor for R6, sampled shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (!rst && prevValid) begin
      if (absi(int'(offsetPpm) - prevOff) > maxDelta)
        maxDelta = absi(int'(offsetPpm) - prevOff);
    end
    prevOff   = int'(offsetPpm);
    prevValid = !rst;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string depthTag;
    int    d;
    step(3);
    chk(offsetPpm == 0, "R9 reset offset", int'(offsetPpm), 0);
    chk(settled == 1'b0, "R9 reset settled", int'(settled), 0);

    for (int v = 0; v < NV; v++) begin
      d = V_DEPTH[v];
      depthTag = (d == 0) ? "R3 depth" : "R2 depth";
      startAt(V_HI[v], V_LO[v]);
      chk(offsetPpm == 0, "R9 offset after reset", int'(offsetPpm), 0);
      chk(settled == 1'b0, "R8 settled after reset", int'(settled), 0);
      step(211);
      chk(absi(-int'(offsetPpm) - d / 2) <= 2, "R5 mid falling", -int'(offsetPpm), d / 2);
      chk(offsetPpm <= 0, "R1 sign", int'(offsetPpm), 0);
      step(211);
      chk(int'(offsetPpm) == -d, depthTag, int'(offsetPpm), -d);
      step(211);
      chk(absi(-int'(offsetPpm) - d / 2) <= 2, "R5 mid rising", -int'(offsetPpm), d / 2);
      step(210);
      chk(settled == 1'b0, "R8 before first period end", int'(settled), 0);
      step(1);
      chk(offsetPpm == 0, "R4 back at zero", int'(offsetPpm), 0);
      chk(settled == 1'b1, "R8 settled at period end", int'(settled), 1);
    end

    // Change in the middle of a falling ramp.
    startAt(2'd0, 2'd1);
    step(900);
    selHi = 2'd2; selLo = 2'd0;
    step(5);
    chk(settled == 1'b0, "R8 drop on change", int'(settled), 0);
    step(361);
    chk(int'(offsetPpm) == -5000, "R7 old peak kept", int'(offsetPpm), -5000);
    step(844);
    chk(int'(offsetPpm) == -15000, "R7 new peak", int'(offsetPpm), -15000);
    step(421);
    chk(settled == 1'b0, "R8 not yet settled", int'(settled), 0);
    step(1);
    chk(settled == 1'b1, "R8 settled at new depth", int'(settled), 1);

    // Registered change lands one clock before the return to zero.
    startAt(2'd0, 2'd1);
    step(1686);
    selHi = 2'd1; selLo = 2'd1;
    step(2);
    chk(settled == 1'b0, "R8 change before zero", int'(settled), 0);
    step(422);
    chk(int'(offsetPpm) == -7500, "R7 loaded at zero", int'(offsetPpm), -7500);

    // Registered change lands on the return to zero itself.
    startAt(2'd0, 2'd1);
    step(1687);
    selHi = 2'd1; selLo = 2'd1;
    step(1);
    chk(settled == 1'b1, "R8 old period settled", int'(settled), 1);
    step(1);
    chk(settled == 1'b0, "R8 drop after zero", int'(settled), 0);
    step(421);
    chk(int'(offsetPpm) == -5000, "R7 old depth one more period", int'(offsetPpm), -5000);
    step(844);
    chk(int'(offsetPpm) == -7500, "R7 new depth next period", int'(offsetPpm), -7500);

    // Reset in the middle of a ramp takes the present inputs.
    step(100);
    selHi = 2'd0; selLo = 2'd2;
    rst = 1'b1;
    step(1);
    chk(offsetPpm == 0, "R9 mid-ramp reset offset", int'(offsetPpm), 0);
    chk(settled == 1'b0, "R9 mid-ramp reset settled", int'(settled), 0);
    rst = 1'b0;
    step(HALF);
    chk(int'(offsetPpm) == -3750, "R9 depth from reset inputs", int'(offsetPpm), -3750);

    chk(maxDelta <= 46 && maxDelta > 0, "R6 slew", maxDelta, 46);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule